// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control sequencer that sits in front of a successive-conversion analog-to-digital converter. A register write sets or clears a start bit and selects single-shot or continuous operation. The sequencer counts system clock cycles to model the converter's wake-up delay and its fixed conversion latency. At the end of each conversion it captures a 13-bit two's-complement sample into a pair of 8-bit result registers and pulses an interrupt request.

In single-shot mode the start bit drops back to zero when the result lands. In continuous mode conversions follow one another with no gap until software writes the start bit low, and each result overwrites the one before. When the converter has sat idle for a long stretch it is put to sleep. The next start then pays an extra wake-up delay first.

The converter output `sample_i` is a plain level with no valid/ready handshake. It is taken on the clock edge that ends each conversion. The result registers have no back-pressure: a result that is not read before the next conversion ends is overwritten. The control and status pins are plain levels.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The start bit is set by a clock edge with `wr_en`=1 and `wr_start`=1 while `busy`=0. `busy` is 1 from the following cycle and stays 1 until the conversion completes.
- R2: A start issued while awake completes 5129 clock edges after the start edge. `busy` is high for exactly 5129 cycles, and `irq` is high in the cycle right after the completing edge.
- R3: A start issued while `powered_down`=1 first spends 40 wake-up cycles and then 5129 conversion cycles, so the completion comes 5169 edges after the start edge.
- R4: On completion, sample bits [12:5] appear on `data_hi[7:0]` and sample bits [4:0] appear on `data_lo[7:3]`. `data_lo[2:0]` always read 0.
- R5: `irq` is a pulse one cycle wide, given once per completed conversion. In single-shot mode (`wr_cont`=0 at start) `busy` is 0 in the same cycle that `irq` is high.
- R6: `powered_down` rises only after 160 consecutive idle cycles that follow a completion (or reset). `irq` stays low during those idle cycles.
- R7: Once `powered_down` is high it stays high until a start write. It reads 0 in the cycle after that start edge.
- R8: In continuous mode (`wr_cont`=1 at start) a new conversion begins on the completing edge with no wake-up delay. `busy` stays 1, `irq` repeats every 5129 cycles, and each result overwrites the data registers.
- R9: A write with `wr_start`=0 during a continuous run lets the current conversion finish, and no further conversion follows. `busy` is 0 from the `irq` cycle onward.
- R10: A start write while `busy`=1 is ignored. It neither restarts the cycle count nor changes the mode, so completion timing and the single-shot stop are unchanged.
- R11: After reset `busy`, `irq` and `powered_down` are 0, and both data registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_start | input | 1 | Start bit value carried by the write |
| wr_cont | input | 1 | Mode carried by the write: 1 continuous, 0 single-shot |
| sample_i | input | 13 | Converter result, two's complement, taken on the completing edge |
| busy | output | 1 | Start bit readback, high while waking or converting |
| data_hi | output | 8 | Result bits [12:5] |
| data_lo | output | 8 | Result bits [4:0] in [7:3]; [2:0] are zero |
| irq | output | 1 | Conversion-complete pulse |
| powered_down | output | 1 | Converter asleep after the idle timeout |

## Verification
The assertions check several properties on every cycle. A start from idle raises busy, and a repeated start mid-conversion still advances the cycle count by one. The interrupt never lasts two cycles. A sleeping converter stays asleep until woken and is never asleep while busy. A continuous run rolls into the next conversion without a wake-up phase. The exact latencies of 5129, 5169 and 160 cycles, the bit placement of the captured result, and the point at which a stop request ends a continuous run can only be shown by the bench's timed scenarios.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W   = 13,
  parameter int MAX_CNT = 5128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign last = (cnt == target);

  // R2: the phase counter never runs past the longest phase
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/adc_seq_idle.sv
module adc_seq_idle #(
  parameter int IDLE_CYCLES = 160,
  localparam int IW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic wake,
  output logic powered_down
);
  logic [IW-1:0] idle_cnt;
  logic          timeout;

  assign timeout = idle && !powered_down && (idle_cnt == IW'(IDLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !idle || wake) idle_cnt <= '0;
    else if (!powered_down)      idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       powered_down <= 1'b0;
    else if (wake)    powered_down <= 1'b0;
    else if (timeout) powered_down <= 1'b1;
  end

  // R7: sleep persists until a wake request
  a_r7_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down && !wake |=> powered_down);
  // R6: the converter only sleeps while the sequencer is idle
  a_r6_pd_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> idle);
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int SAMPLE_W = 13,
  parameter int REG_W    = 8,
  localparam int LO_BITS = SAMPLE_W - REG_W,
  localparam int PAD     = 2 * REG_W - SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [REG_W-1:0]    data_hi,
  output logic [REG_W-1:0]    data_lo,
  output logic                irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_hi <= '0;
      data_lo <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= capture;
      if (capture) begin
        data_hi <= sample[SAMPLE_W-1:LO_BITS];
        data_lo <= {sample[LO_BITS-1:0], {PAD{1'b0}}};
      end
    end
  end

  // R5: completion request is a single-cycle pulse
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CONV_CYCLES = 5129,
  parameter int WAKE_CYCLES = 40,
  parameter int IDLE_CYCLES = 160,
  parameter int SAMPLE_W    = 13,
  parameter int REG_W       = 8,
  localparam int CNT_W = $clog2(CONV_CYCLES + WAKE_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_start,
  input  logic                wr_cont,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                busy,
  output logic [REG_W-1:0]    data_hi,
  output logic [REG_W-1:0]    data_lo,
  output logic                irq,
  output logic                powered_down
);
  import adc_seq_pkg::*;

  seq_state_e       state_q, state_d;
  logic             repeat_q, repeat_d;
  logic             start_req, stop_req, wake_req;
  logic             tmr_clr, tmr_last, complete;
  logic [CNT_W-1:0] tmr_cnt, tmr_target;

  assign start_req = wr_en && wr_start;
  assign stop_req  = wr_en && !wr_start;
  assign wake_req  = (state_q == ST_IDLE) && start_req;
  assign complete  = (state_q == ST_CONV) && tmr_last;
  assign busy      = (state_q != ST_IDLE);

  assign tmr_target = (state_q == ST_WAKE) ? CNT_W'(WAKE_CYCLES - 1)
                                           : CNT_W'(CONV_CYCLES - 1);
  assign tmr_clr    = (state_q == ST_IDLE) || tmr_last;

  always_comb begin
    state_d  = state_q;
    repeat_d = repeat_q;
    unique case (state_q)
      ST_IDLE: if (start_req) begin
        state_d  = powered_down ? ST_WAKE : ST_CONV;
        repeat_d = wr_cont;
      end
      ST_WAKE: begin
        if (stop_req) repeat_d = 1'b0;
        if (tmr_last) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (stop_req) repeat_d = 1'b0;
        if (tmr_last && !(repeat_q && !stop_req)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      repeat_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      repeat_q <= repeat_d;
    end
  end

  adc_seq_timer #(.CNT_W(CNT_W), .MAX_CNT(CONV_CYCLES - 1)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .target(tmr_target),
    .cnt(tmr_cnt), .last(tmr_last)
  );

  adc_seq_idle #(.IDLE_CYCLES(IDLE_CYCLES)) idle_i (
    .clk(clk), .rst_n(rst_n), .idle(state_q == ST_IDLE), .wake(wake_req),
    .powered_down(powered_down)
  );

  adc_seq_result #(.SAMPLE_W(SAMPLE_W), .REG_W(REG_W)) result_i (
    .clk(clk), .rst_n(rst_n), .capture(complete), .sample(sample_i),
    .data_hi(data_hi), .data_lo(data_lo), .irq(irq)
  );

  // R1: a start from idle raises the start-bit readback
  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_req |=> busy);
  // R10: a repeated start mid-conversion does not reset the cycle count
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) && start_req && !tmr_last |=> tmr_cnt == $past(tmr_cnt) + 1'b1);
  // R8: a continuous run rolls straight into the next conversion
  a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    complete && repeat_q && !stop_req |=> (state_q == ST_CONV) && (tmr_cnt == '0));
  // R6: never asleep while converting
  a_r6_not_busy_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> !busy);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_start = 1'b0, wr_cont = 1'b0;
  logic [12:0] sample_i = '0;
  logic        busy, irq, powered_down;
  logic [7:0]  data_hi, data_lo;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
    .wr_cont(wr_cont), .sample_i(sample_i), .busy(busy), .data_hi(data_hi),
    .data_lo(data_lo), .irq(irq), .powered_down(powered_down)
  );

  // sample[28:16], expected data_hi[15:8], expected data_lo[7:0]
  localparam logic [28:0] VEC [6] = '{
    {13'h0000, 8'h00, 8'h00},
    {13'h1FFF, 8'hFF, 8'hF8},
    {13'h1000, 8'h80, 8'h00},
    {13'h0FFF, 8'h7F, 8'hF8},
    {13'h0ABC, 8'h55, 8'hE0},
    {13'h1555, 8'hAA, 8'hA8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic s, input logic c);
    @(negedge clk);
    wr_en = 1'b1; wr_start = s; wr_cont = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts negedges until irq; optionally pokes a write at count poke_at
  task automatic run_to_irq(input int poke_at, input logic ps, input logic pc,
                            output int n, output int busy_drop);
    n = 0;
    busy_drop = 0;
    while (!irq && n < 12000) begin
      @(negedge clk);
      n++;
      if (n == poke_at) begin wr_en = 1'b1; wr_start = ps; wr_cont = pc; end
      if (n == poke_at + 1) wr_en = 1'b0;
      if (!busy && !irq) busy_drop++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, bd;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0); chk("R11 irq", irq, 0);
    chk("R11 pd", powered_down, 0);
    chk("R11 data", {data_hi, data_lo}, 0);
    rst_n = 1'b1;

    // R2/R4/R5: single-shot vectors from the awake state
    for (int i = 0; i < 6; i++) begin
      sample_i = VEC[i][28:16];
      write_ctl(1'b1, 1'b0);
      chk("R1 busy after start", busy, 1);
      run_to_irq(-5, 1'b0, 1'b0, n, bd);
      chk("R2 latency", n, 5129);
      chk("R1 busy held", bd, 0);
      chk("R5 busy clear at irq", busy, 0);
      chk("R4 data_hi", data_hi, VEC[i][15:8]);
      chk("R4 data_lo", data_lo, VEC[i][7:0]);
      @(negedge clk);
      chk("R5 irq one cycle", irq, 0);
    end

    // R10: repeated start with continuous mode mid-conversion is ignored
    sample_i = 13'h0123;
    write_ctl(1'b1, 1'b0);
    run_to_irq(1000, 1'b1, 1'b1, n, bd);
    chk("R10 latency unchanged", n, 5129);
    chk("R10 single stop kept", busy, 0);
    repeat (3) @(negedge clk);
    chk("R10 no further conversion", busy, 0);

    // R8/R9: continuous run, stopped during the second conversion
    sample_i = 13'h0ABC;
    write_ctl(1'b1, 1'b1);
    run_to_irq(-5, 1'b0, 1'b0, n, bd);
    chk("R8 first latency", n, 5129);
    chk("R8 busy stays", busy, 1);
    chk("R8 data first", data_hi, 8'h55);
    sample_i = 13'h1555;
    @(negedge clk);
    chk("R8 irq pulse", irq, 0);
    run_to_irq(2000, 1'b0, 1'b1, n, bd);
    chk("R8 back-to-back period", n + 1, 5129);
    chk("R8 data overwritten", {data_hi, data_lo}, 16'hAAA8);
    chk("R9 stop after current", busy, 0);

    // R6: sleep after 160 idle cycles, no irq meanwhile
    bd = 0;
    for (int k = 1; k <= 159; k++) begin
      @(negedge clk);
      if (powered_down || irq || busy) bd++;
    end
    chk("R6 awake before timeout", bd, 0);
    @(negedge clk);
    chk("R6 asleep at 160", powered_down, 1);

    // R7: stays asleep, wakes on start; R3: wake-up penalty
    repeat (300) @(negedge clk);
    chk("R7 sleep held", powered_down, 1);
    sample_i = 13'h0FFF;
    write_ctl(1'b1, 1'b0);
    chk("R7 cleared by start", powered_down, 0);
    run_to_irq(-5, 1'b0, 1'b0, n, bd);
    chk("R3 latency from sleep", n, 5169);
    chk("R3 data", {data_hi, data_lo}, 16'h7FF8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule